// File: doc/BRIEF.md
# Flash Command Opcode Parser

This block sits behind the byte assembler of a serial flash target that either answers commands itself (flash mode) or forwards them to a real memory (pass-through mode). The first byte seen after chip select falls is compared against a table of command entries that software programs. Each entry is a valid bit, an opcode and a word of attributes. Once a byte has been decoded, a one-shot state machine parks in the handling state for that command until chip select rises again.

While parked, the block presents a one-hot select to exactly one downstream engine: status, identification, discovery table, read, upload, address-width enter/exit, or write-latch set/clear. It also presents the attributes and slot number of the entry that won the decode. In pass-through mode the three register-style read commands are served locally only when their intercept enables are set. A registered flag tells the forwarding logic that the command was taken locally.

Top module: `opcode_parser`

## Requirements
- R1: After reset, and in the cycle after any cycle with `cs_n` high, `busy_o`, `path_sel_o`, `cmd_hit_o`, `cmd_attr_o`, `cmd_slot_o` and all three intercept flags are zero.
- R2: An entry matches only when its bit in `tbl_valid` is 1 and its opcode field equals `byte_data`. A byte with no match moves the parser to a waiting state: `busy_o`=1, `path_sel_o`=0, `cmd_hit_o`=0.
- R3: A byte is decoded only when the parser is idle, active and `byte_vld` is 1, with `cs_n` low. Outputs update one clock later and then hold, ignoring further bytes, until `cs_n` goes high.
- R4: `mode_i`=2'b01 is flash mode and 2'b10 is pass-through. With `mode_i` 2'b00 or 2'b11 bytes are ignored and `busy_o` stays 0.
- R5: Slot layout and select bits (`path_sel_o` bit in brackets): slots 0-2 status [0], slot 3 identification [1], slot 4 discovery [2], slots 9 to 9+READ_SLOTS-1 read [3], higher slots upload [4], slot 5 enter wide address [5], slot 6 exit wide address [6], slot 7 write-latch set [7], slot 8 write-latch clear [8].
- R6: When several classes match, the winner follows this order: status, identification, discovery, read, upload, wide address (enter before exit), write latch (set before clear).
- R7: In pass-through mode a status, identification or discovery match takes its handling state only if its intercept enable is 1. Otherwise the parser waits with `path_sel_o`=0. In flash mode the enable is ignored.
- R8: An intercept flag is 1 only after its command was taken locally in pass-through mode. Flash mode never sets a flag.
- R9: On a match, `cmd_hit_o`=1 and `cmd_attr_o`/`cmd_slot_o` give the winning entry's attributes and index, even when a pass-through command is not intercepted.
- R10: Among overlapping generic slots the lowest index wins.
- R11: `path_sel_o` has at most one bit set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high clears the parser |
| mode_i | input | 2 | 01 flash, 10 pass-through, else inactive |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | OPW | Received byte |
| tbl_valid | input | N | Per-slot valid bits |
| tbl_opcode | input | N*OPW | Per-slot opcodes, slot i at bits i*OPW |
| tbl_attr | input | N*ATTR_W | Per-slot attributes, slot i at bits i*ATTR_W |
| icpt_en_status | input | 1 | Serve status reads locally in pass-through |
| icpt_en_ident | input | 1 | Serve identification locally in pass-through |
| icpt_en_disc | input | 1 | Serve discovery table locally in pass-through |
| busy_o | output | 1 | Opcode consumed for this transaction |
| path_sel_o | output | 9 | One-hot downstream engine select |
| cmd_hit_o | output | 1 | Latched entry is valid |
| cmd_attr_o | output | ATTR_W | Attributes of the winning entry |
| cmd_slot_o | output | clog2(N) | Index of the winning entry |
| icpt_status_o | output | 1 | Status read taken locally |
| icpt_ident_o | output | 1 | Identification taken locally |
| icpt_disc_o | output | 1 | Discovery read taken locally |

## Verification
The bench goes after opcode collisions. A generic slot duplicates a status opcode, two generic slots share an opcode, and the wide-address and write-latch slots are made to collide. A parser with the wrong priority order routes these to the wrong engine or reports the wrong slot. It also drives an invalid entry whose opcode matches, which a design that ignores the valid bit would accept. It sends a second byte inside a transaction, which a parser that is not one-shot would re-decode. It covers pass-through with the intercept enables off and on, where a wrong design either selects an engine it should leave to the forwarded memory or raises a flag in flash mode. Finally it tries the two inactive mode codes, which a design that does not check the mode would decode.

// File: rtl/opp_pkg.sv
package opp_pkg;

   localparam int SLOT_STAT0  = 0;
   localparam int SLOT_STAT2  = 2;
   localparam int SLOT_IDENT  = 3;
   localparam int SLOT_DISC   = 4;
   localparam int SLOT_ADR_EN = 5;
   localparam int SLOT_ADR_EX = 6;
   localparam int SLOT_WL_SET = 7;
   localparam int SLOT_WL_CLR = 8;
   localparam int FIXED_SLOTS = 9;

   localparam int SB_STATUS = 0;
   localparam int SB_IDENT  = 1;
   localparam int SB_DISC   = 2;
   localparam int SB_READ   = 3;
   localparam int SB_UPLOAD = 4;
   localparam int SB_ADR_EN = 5;
   localparam int SB_ADR_EX = 6;
   localparam int SB_WL_SET = 7;
   localparam int SB_WL_CLR = 8;
   localparam int SEL_W     = 9;

   localparam logic [1:0] MODE_FLASH = 2'b01;
   localparam logic [1:0] MODE_PASS  = 2'b10;

   typedef enum logic [3:0] {
      PST_IDLE,
      PST_STATUS,
      PST_IDENT,
      PST_DISC,
      PST_READ,
      PST_UPLOAD,
      PST_ADDRW,
      PST_WLATCH,
      PST_WAIT
   } parse_st_e;

   typedef struct packed {
      logic status;
      logic ident;
      logic disc;
   } icpt_t;

endpackage

// File: rtl/opp_slot_match.sv
module opp_slot_match #(
   parameter int N   = 16,
   parameter int OPW = 8
) (
   input  logic [N-1:0]     tbl_valid,
   input  logic [N*OPW-1:0] tbl_opcode,
   input  logic [OPW-1:0]   byte_data,
   output logic [N-1:0]     hit
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = tbl_valid[i] && (tbl_opcode[i*OPW +: OPW] == byte_data);
   end
endmodule

// File: rtl/opp_prio_pick.sv
module opp_prio_pick #(
   parameter int N  = 16,
   parameter int LO = 0,
   parameter int HI = 0,
   parameter int IW = 4
) (
   input  logic [N-1:0]  hit,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (HI >= LO) begin : g_range
      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int i = HI; i >= LO; i--) begin
            if (hit[i]) begin
               any = 1'b1;
               idx = IW'(i);
            end
         end
      end
   end else begin : g_empty
      assign any = 1'b0;
      assign idx = '0;
   end
endmodule

// File: rtl/opp_route.sv
module opp_route
   import opp_pkg::*;
#(
   parameter int N          = 16,
   parameter int IW         = 4,
   parameter int READ_SLOTS = 4
) (
   input  logic [N-1:0]     hit,
   input  logic             in_flash,
   input  logic             in_pass,
   input  logic             en_status,
   input  logic             en_ident,
   input  logic             en_disc,
   output parse_st_e        nxt_st,
   output logic [SEL_W-1:0] nxt_sel,
   output icpt_t            nxt_icpt,
   output logic             win_any,
   output logic [IW-1:0]    win_idx
);
   localparam int READ_LO = FIXED_SLOTS;
   localparam int READ_HI = FIXED_SLOTS + READ_SLOTS - 1;
   localparam int UPL_LO  = FIXED_SLOTS + READ_SLOTS;
   localparam int UPL_HI  = N - 1;

   logic          stat_any, rd_any, up_any;
   logic [IW-1:0] stat_idx, rd_idx, up_idx;

   opp_prio_pick #(.N(N), .LO(SLOT_STAT0), .HI(SLOT_STAT2), .IW(IW)) u_pick_stat (
      .hit(hit), .any(stat_any), .idx(stat_idx));
   opp_prio_pick #(.N(N), .LO(READ_LO), .HI(READ_HI), .IW(IW)) u_pick_read (
      .hit(hit), .any(rd_any), .idx(rd_idx));
   opp_prio_pick #(.N(N), .LO(UPL_LO), .HI(UPL_HI), .IW(IW)) u_pick_upl (
      .hit(hit), .any(up_any), .idx(up_idx));

   logic local_stat, local_ident, local_disc;
   assign local_stat  = in_flash || en_status;
   assign local_ident = in_flash || en_ident;
   assign local_disc  = in_flash || en_disc;

   always_comb begin
      nxt_st   = PST_WAIT;
      nxt_sel  = '0;
      nxt_icpt = '0;
      win_any  = 1'b1;
      win_idx  = '0;
      if (stat_any) begin
         win_idx = stat_idx;
         if (local_stat) begin
            nxt_st               = PST_STATUS;
            nxt_sel[SB_STATUS]   = 1'b1;
            nxt_icpt.status      = in_pass;
         end
      end else if (hit[SLOT_IDENT]) begin
         win_idx = IW'(SLOT_IDENT);
         if (local_ident) begin
            nxt_st             = PST_IDENT;
            nxt_sel[SB_IDENT]  = 1'b1;
            nxt_icpt.ident     = in_pass;
         end
      end else if (hit[SLOT_DISC]) begin
         win_idx = IW'(SLOT_DISC);
         if (local_disc) begin
            nxt_st            = PST_DISC;
            nxt_sel[SB_DISC]  = 1'b1;
            nxt_icpt.disc     = in_pass;
         end
      end else if (rd_any) begin
         win_idx          = rd_idx;
         nxt_st           = PST_READ;
         nxt_sel[SB_READ] = 1'b1;
      end else if (up_any) begin
         win_idx            = up_idx;
         nxt_st             = PST_UPLOAD;
         nxt_sel[SB_UPLOAD] = 1'b1;
      end else if (hit[SLOT_ADR_EN] || hit[SLOT_ADR_EX]) begin
         nxt_st = PST_ADDRW;
         if (hit[SLOT_ADR_EN]) begin
            win_idx            = IW'(SLOT_ADR_EN);
            nxt_sel[SB_ADR_EN] = 1'b1;
         end else begin
            win_idx            = IW'(SLOT_ADR_EX);
            nxt_sel[SB_ADR_EX] = 1'b1;
         end
      end else if (hit[SLOT_WL_SET] || hit[SLOT_WL_CLR]) begin
         nxt_st = PST_WLATCH;
         if (hit[SLOT_WL_SET]) begin
            win_idx            = IW'(SLOT_WL_SET);
            nxt_sel[SB_WL_SET] = 1'b1;
         end else begin
            win_idx            = IW'(SLOT_WL_CLR);
            nxt_sel[SB_WL_CLR] = 1'b1;
         end
      end else begin
         win_any = 1'b0;
      end
   end
endmodule

// File: rtl/opcode_parser.sv
module opcode_parser
   import opp_pkg::*;
#(
   parameter int N          = 16,
   parameter int OPW        = 8,
   parameter int ATTR_W     = 8,
   parameter int READ_SLOTS = 4,
   localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic [1:0]          mode_i,
   input  logic                byte_vld,
   input  logic [OPW-1:0]      byte_data,
   input  logic [N-1:0]        tbl_valid,
   input  logic [N*OPW-1:0]    tbl_opcode,
   input  logic [N*ATTR_W-1:0] tbl_attr,
   input  logic                icpt_en_status,
   input  logic                icpt_en_ident,
   input  logic                icpt_en_disc,
   output logic                busy_o,
   output logic [SEL_W-1:0]    path_sel_o,
   output logic                cmd_hit_o,
   output logic [ATTR_W-1:0]   cmd_attr_o,
   output logic [IW-1:0]       cmd_slot_o,
   output logic                icpt_status_o,
   output logic                icpt_ident_o,
   output logic                icpt_disc_o
);

   if (N <= FIXED_SLOTS) begin : g_chk_n
      $error("opcode_parser: N must exceed the fixed slot count");
   end
   if (READ_SLOTS < 0 || READ_SLOTS > N - FIXED_SLOTS) begin : g_chk_rd
      $error("opcode_parser: READ_SLOTS out of range");
   end
   if (OPW < 1 || ATTR_W < 1) begin : g_chk_w
      $error("opcode_parser: widths must be positive");
   end

   parse_st_e        st_q, nxt_st;
   logic [SEL_W-1:0] sel_q, nxt_sel;
   icpt_t            icpt_q, nxt_icpt;
   logic             hit_q, win_any;
   logic [IW-1:0]    slot_q, win_idx;
   logic [ATTR_W-1:0] attr_q;
   logic [N-1:0]     hit;
   logic             in_flash, in_pass, active, take;

   assign in_flash = (mode_i == MODE_FLASH);
   assign in_pass  = (mode_i == MODE_PASS);
   assign active   = in_flash || in_pass;
   assign take     = (st_q == PST_IDLE) && active && byte_vld;

   logic [ATTR_W-1:0] attr_arr [N];
   for (genvar i = 0; i < N; i++) begin : g_attr
      assign attr_arr[i] = tbl_attr[i*ATTR_W +: ATTR_W];
   end

   opp_slot_match #(.N(N), .OPW(OPW)) u_match (
      .tbl_valid (tbl_valid),
      .tbl_opcode(tbl_opcode),
      .byte_data (byte_data),
      .hit       (hit)
   );

   opp_route #(.N(N), .IW(IW), .READ_SLOTS(READ_SLOTS)) u_route (
      .hit      (hit),
      .in_flash (in_flash),
      .in_pass  (in_pass),
      .en_status(icpt_en_status),
      .en_ident (icpt_en_ident),
      .en_disc  (icpt_en_disc),
      .nxt_st   (nxt_st),
      .nxt_sel  (nxt_sel),
      .nxt_icpt (nxt_icpt),
      .win_any  (win_any),
      .win_idx  (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PST_IDLE;
         sel_q  <= '0;
         icpt_q <= '0;
         hit_q  <= 1'b0;
         slot_q <= '0;
         attr_q <= '0;
      end else if (cs_n) begin
         st_q   <= PST_IDLE;
         sel_q  <= '0;
         icpt_q <= '0;
         hit_q  <= 1'b0;
         slot_q <= '0;
         attr_q <= '0;
      end else if (take) begin
         st_q   <= nxt_st;
         sel_q  <= nxt_sel;
         icpt_q <= nxt_icpt;
         hit_q  <= win_any;
         slot_q <= win_any ? win_idx : '0;
         attr_q <= win_any ? attr_arr[win_idx] : '0;
      end
   end

   assign busy_o        = (st_q != PST_IDLE);
   assign path_sel_o    = sel_q;
   assign cmd_hit_o     = hit_q;
   assign cmd_attr_o    = attr_q;
   assign cmd_slot_o    = slot_q;
   assign icpt_status_o = icpt_q.status;
   assign icpt_ident_o  = icpt_q.ident;
   assign icpt_disc_o   = icpt_q.disc;

endmodule

// File: rtl/opp_checker.sv
module opp_checker #(
   parameter int SEL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic [1:0]       mode_i,
   input logic             byte_vld,
   input logic             busy_o,
   input logic [SEL_W-1:0] path_sel_o,
   input logic             cmd_hit_o,
   input logic             icpt_status_o,
   input logic             icpt_ident_o,
   input logic             icpt_disc_o
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(path_sel_o)); // R11

   AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!busy_o && path_sel_o == '0 && !cmd_hit_o &&
                !icpt_status_o && !icpt_ident_o && !icpt_disc_o)); // R1

   AST_ONE_SHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !cs_n) |=> (busy_o && $stable(path_sel_o) && $stable(cmd_hit_o))); // R3

   AST_INACTIVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cs_n && (mode_i == 2'b00 || mode_i == 2'b11)) |=> !busy_o); // R4

   AST_FLAG_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cs_n && byte_vld && mode_i != 2'b10) |=>
      (!icpt_status_o && !icpt_ident_o && !icpt_disc_o)); // R8

   AST_SEL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (path_sel_o != '0) |-> busy_o); // R5

   AST_FLAG_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (icpt_status_o |-> path_sel_o[0]) and (icpt_ident_o |-> path_sel_o[1]) and
      (icpt_disc_o |-> path_sel_o[2])); // R7
endmodule

bind opcode_parser opp_checker #(.SEL_W(opp_pkg::SEL_W)) u_opp_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .mode_i       (mode_i),
   .byte_vld     (byte_vld),
   .busy_o       (busy_o),
   .path_sel_o   (path_sel_o),
   .cmd_hit_o    (cmd_hit_o),
   .icpt_status_o(icpt_status_o),
   .icpt_ident_o (icpt_ident_o),
   .icpt_disc_o  (icpt_disc_o)
);

// File: tb/opcode_parser_bench.sv
`timescale 1ns/1ps
module opcode_parser_bench;
   localparam int N = 16, OPW = 8, AW = 8, RS = 4, IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic [1:0] mode_i = 2'b01;
   logic byte_vld = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [N-1:0] tbl_valid;
   logic [N*OPW-1:0] tbl_opcode;
   logic [N*AW-1:0] tbl_attr;
   logic en_st = 1'b0, en_id = 1'b0, en_ds = 1'b0;
   logic busy_o, cmd_hit_o, icpt_status_o, icpt_ident_o, icpt_disc_o;
   logic [8:0] path_sel_o;
   logic [AW-1:0] cmd_attr_o;
   logic [IW-1:0] cmd_slot_o;

   always #5 clk = ~clk;

   opcode_parser #(.N(N), .OPW(OPW), .ATTR_W(AW), .READ_SLOTS(RS)) u_opcode_parser (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_i(mode_i),
      .byte_vld(byte_vld), .byte_data(byte_data),
      .tbl_valid(tbl_valid), .tbl_opcode(tbl_opcode), .tbl_attr(tbl_attr),
      .icpt_en_status(en_st), .icpt_en_ident(en_id), .icpt_en_disc(en_ds),
      .busy_o(busy_o), .path_sel_o(path_sel_o), .cmd_hit_o(cmd_hit_o),
      .cmd_attr_o(cmd_attr_o), .cmd_slot_o(cmd_slot_o),
      .icpt_status_o(icpt_status_o), .icpt_ident_o(icpt_ident_o), .icpt_disc_o(icpt_disc_o));

   int t_op [N];
   bit t_v  [N];
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   bit m_busy, m_hit, m_ist, m_iid, m_ids;
   int m_sel, m_attr, m_slot;

   task automatic load_table();
      for (int i = 0; i < N; i++) begin
         tbl_valid[i] = t_v[i];
         tbl_opcode[i*OPW +: OPW] = 8'(t_op[i]);
         tbl_attr[i*AW +: AW] = 8'(8'h10 + i);
      end
   endtask

   task automatic model_clear();
      m_busy = 0; m_hit = 0; m_ist = 0; m_iid = 0; m_ids = 0;
      m_sel = 0; m_attr = 0; m_slot = 0;
   endtask

   // priority classes: status, ident, disc, read, upload, addr width, write latch
   task automatic model_decode(int b);
      int lo [7] = '{0, 3, 4, 9, 13, 5, 7};
      int hi [7] = '{2, 3, 4, 12, 15, 6, 8};
      int cls = -1, slot = -1;
      bit pass = (mode_i == 2'b10);
      for (int g = 0; g < 7 && cls < 0; g++)
         for (int s = lo[g]; s <= hi[g] && slot < 0; s++)
            if (t_v[s] && t_op[s] == b) begin cls = g; slot = s; end
      m_busy = 1;
      m_hit = (cls >= 0);
      m_slot = m_hit ? slot : 0;
      m_attr = m_hit ? 8'h10 + slot : 0;
      m_sel = 0;
      case (cls)
         0: if (!pass || en_st) begin m_sel = 1 << 0; m_ist = pass; end
         1: if (!pass || en_id) begin m_sel = 1 << 1; m_iid = pass; end
         2: if (!pass || en_ds) begin m_sel = 1 << 2; m_ids = pass; end
         3: m_sel = 1 << 3;
         4: m_sel = 1 << 4;
         5, 6: m_sel = 1 << slot;
         default: m_sel = 0;
      endcase
   endtask

   task automatic model_update();
      if (!rst_n || cs_n) model_clear();
      else if (!m_busy && (mode_i == 2'b01 || mode_i == 2'b10) && byte_vld)
         model_decode(int'(byte_data));
   endtask

   task automatic chk(string tag, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R3 model busy", int'(busy_o), int'(m_busy));
      chk("R5 model sel", int'(path_sel_o), m_sel);
      chk("R9 model hit", int'(cmd_hit_o), int'(m_hit));
      chk("R9 model attr", int'(cmd_attr_o), m_attr);
      chk("R9 model slot", int'(cmd_slot_o), m_slot);
      chk("R8 model flags", int'({icpt_status_o, icpt_ident_o, icpt_disc_o}),
          int'({m_ist, m_iid, m_ids}));
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_model();
   endtask

   // one transaction; checks after the opcode byte, after a second byte, after release
   task automatic txn(int b, logic [1:0] m, int e_busy, int e_sel, int e_hit, int e_slot, string tag);
      int sel_first;
      mode_i = m; cs_n = 1'b0; byte_vld = 1'b1; byte_data = 8'(b);
      step();
      chk({tag, " busy"}, int'(busy_o), e_busy);
      chk({tag, " sel"}, int'(path_sel_o), e_sel);
      chk({tag, " hit"}, int'(cmd_hit_o), e_hit);
      if (e_hit != 0) begin
         chk({tag, " slot R9"}, int'(cmd_slot_o), e_slot);
         chk({tag, " attr R9"}, int'(cmd_attr_o), 8'h10 + e_slot);
      end
      sel_first = int'(path_sel_o);
      byte_data = 8'h05;
      step();
      chk("R3 second byte ignored", int'(path_sel_o), sel_first);
      byte_vld = 1'b0;
      step();
      cs_n = 1'b1;
      step();
      chk("R1 released", int'({busy_o, path_sel_o, cmd_hit_o, icpt_status_o, icpt_ident_o, icpt_disc_o}), 0);
   endtask

   initial begin
      int ops [N] = '{8'h05, 8'h35, 8'h15, 8'h9F, 8'h5A, 8'hB7, 8'hE9, 8'h06,
                      8'h04, 8'h03, 8'h0B, 8'h3B, 8'h03, 8'h02, 8'h05, 8'h32};
      for (int i = 0; i < N; i++) begin t_op[i] = ops[i]; t_v[i] = (i != 11); end
      load_table();
      model_clear();
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 reset state", int'({busy_o, path_sel_o, cmd_hit_o, cmd_attr_o, cmd_slot_o}), 0);

      txn(8'h9F, 2'b01, 1, 9'h002, 1, 3, "R5 ident");
      txn(8'h05, 2'b01, 1, 9'h001, 1, 0, "R6 status over generic");
      txn(8'h15, 2'b01, 1, 9'h001, 1, 2, "R5 status slot2");
      txn(8'h5A, 2'b01, 1, 9'h004, 1, 4, "R5 disc");
      txn(8'h03, 2'b01, 1, 9'h008, 1, 9, "R10 lowest generic");
      txn(8'h02, 2'b01, 1, 9'h010, 1, 13, "R5 upload");
      txn(8'hB7, 2'b01, 1, 9'h020, 1, 5, "R5 enter wide");
      txn(8'hE9, 2'b10, 1, 9'h040, 1, 6, "R5 exit wide");
      txn(8'h06, 2'b01, 1, 9'h080, 1, 7, "R5 latch set");
      txn(8'h04, 2'b01, 1, 9'h100, 1, 8, "R5 latch clear");
      txn(8'h3B, 2'b01, 1, 9'h000, 0, 0, "R2 invalid entry");
      txn(8'hAA, 2'b01, 1, 9'h000, 0, 0, "R2 no match");
      txn(8'h9F, 2'b00, 0, 9'h000, 0, 0, "R4 mode off");
      txn(8'h9F, 2'b11, 0, 9'h000, 0, 0, "R4 mode reserved");

      // pass-through without and with interception
      txn(8'h05, 2'b10, 1, 9'h000, 1, 0, "R7 status forwarded");
      en_st = 1'b1; en_ds = 1'b1;
      mode_i = 2'b10; cs_n = 1'b0; byte_vld = 1'b1; byte_data = 8'h35;
      step();
      chk("R7 status local sel", int'(path_sel_o), 9'h001);
      chk("R8 status flag", int'(icpt_status_o), 1);
      byte_vld = 1'b0; cs_n = 1'b1;
      step();
      txn(8'h9F, 2'b10, 1, 9'h000, 1, 3, "R7 ident forwarded");
      txn(8'h5A, 2'b10, 1, 9'h004, 1, 4, "R7 disc local");
      txn(8'h35, 2'b01, 1, 9'h001, 1, 1, "R8 flash no flag");
      en_st = 1'b0; en_ds = 1'b0;

      // collisions between wide-address and write-latch slots
      t_op[7] = 8'hB7; t_op[6] = 8'hB7; load_table();
      txn(8'hB7, 2'b01, 1, 9'h020, 1, 5, "R6 enter before exit and latch");
      t_v[5] = 1'b0; load_table();
      txn(8'hB7, 2'b01, 1, 9'h040, 1, 6, "R6 exit before latch");
      t_v[6] = 1'b0; load_table();
      txn(8'hB7, 2'b01, 1, 9'h080, 1, 7, "R6 latch set");
      t_v[12] = 1'b1; t_op[9] = 8'h77; load_table();
      txn(8'h03, 2'b01, 1, 9'h008, 1, 12, "R10 next generic");

      // cs_n high during a byte is ignored
      cs_n = 1'b1; mode_i = 2'b01; byte_vld = 1'b1; byte_data = 8'h06;
      step();
      chk("R1 cs high ignores byte", int'(busy_o), 0);
      byte_vld = 1'b0;
      step();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule